// File: doc/BRIEF.md
# One-Shot Waveform Generator

This block drives a single output bit through exactly one event after reset: a rising step, a falling step, or a rectangular pulse of fixed width. The event shape, the number of clock cycles that pass before it, and the pulse width are all elaboration-time parameters. After the event the output stays at its final level until reset or a clear.

Two optional controls exist. The first is a clock-enable input that pauses the whole sequence while it is low. The second is a synchronous clear that starts the sequence again from the beginning. Each control is switched in by its own parameter. When a control is switched off, its pin stays on the port list but has no effect. Typical uses are a power-up strobe, a delayed release of a downstream block, or a gate that opens once.

An "advancing edge" is a rising clock edge on which reset is released, clear is not applied, and enable is high (or enable is switched off). Let k be the number of advancing edges since the last reset or clear.

Top module: `oneshot_wavegen`

## Requirements
- R1: With SHAPE = 0 (rise), the output is 0 while k <= DELAY and 1 once k > DELAY, and it never falls without a reset or clear.
- R2: With SHAPE = 1 (fall), the output is 1 while k <= DELAY and 0 once k > DELAY, and it never rises without a reset or clear.
- R3: With SHAPE = 2 (impulse), the output is 1 exactly when DELAY < k <= DELAY + LEN, so it is high for LEN advancing edges and then stays low.
- R4: The transition is driven by the edge on which k reaches DELAY + 1. With DELAY = 0, this is the first advancing edge after reset or clear.
- R5: With USE_ENA = 1, an edge on which ena_i is low and sclr_i is not applied leaves the output and the internal progress unchanged.
- R6: With USE_SCLR = 1, a high sclr_i at a clock edge returns the output to its initial level and restarts the delay from k = 0, whatever the level of ena_i.
- R7: When a clear and the transition edge fall on the same clock edge, the clear wins and the output keeps its initial level.
- R8: With USE_ENA = 0 and USE_SCLR = 0, ena_i and sclr_i have no effect on the output, and every clock edge after reset advances the sequence.
- R9: While rst_ni is low, the output sits at its initial level: 1 for SHAPE = 1, and 0 for the other shapes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ena_i | input | 1 | Clock enable (used when USE_ENA = 1) |
| sclr_i | input | 1 | Synchronous clear, active high (used when USE_SCLR = 1) |
| wave_o | output | 1 | Generated waveform |

## Verification
The clear and the delayed transition can land on the same edge, and so can the clear and a low enable. The bench sets up the first case on purpose. It clears the block, gives exactly DELAY advancing edges, and then raises clear and enable together on the edge that would otherwise cause the transition. It also raises clear while enable is low. In both cases the output is judged against an edge-count model in the bench, which resets k on a clear before it considers enable, so the expected level is the initial one.

// File: rtl/pulse_gen_pkg.sv
package pulse_gen_pkg;

   // Output shape selector; the numeric codes are part of the block contract.
   typedef enum logic [1:0] {
      PSHAPE_RISE    = 2'd0,
      PSHAPE_FALL    = 2'd1,
      PSHAPE_IMPULSE = 2'd2
   } pshape_e;

   // Sequencer phase.
   typedef enum logic [1:0] {
      PH_WAIT = 2'd0,
      PH_ACT  = 2'd1,
      PH_DONE = 2'd2
   } phase_e;

   function automatic int unsigned cnt_width(input int unsigned dly, input int unsigned len);
      int unsigned span;
      span = (dly > len) ? dly : len;
      return (span < 1) ? 1 : $clog2(span + 1);
   endfunction

endpackage

// File: rtl/pulse_gen_gate.sv
module pulse_gen_gate #(
   parameter bit USE_ENA  = 1'b1,
   parameter bit USE_SCLR = 1'b1
) (
   input  logic ena_i,
   input  logic sclr_i,
   output logic adv_o,
   output logic restart_o
);

   generate
      if (USE_ENA) begin : g_ena
         assign adv_o = ena_i;
      end else begin : g_no_ena
         logic unused_ena;
         assign unused_ena = ena_i;
         assign adv_o      = 1'b1;
      end

      if (USE_SCLR) begin : g_clr
         assign restart_o = sclr_i;
      end else begin : g_no_clr
         logic unused_clr;
         assign unused_clr = sclr_i;
         assign restart_o  = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/pulse_gen_seq.sv
module pulse_gen_seq
   import pulse_gen_pkg::*;
#(
   parameter int unsigned DELAY   = 4,
   parameter int unsigned LEN     = 1,
   parameter bit          IMPULSE = 1'b0
) (
   input  logic   clk_i,
   input  logic   rst_ni,
   input  logic   adv_i,
   input  logic   restart_i,
   output phase_e phase_o
);

   localparam int unsigned CNT_W = cnt_width(DELAY, LEN);
   localparam logic [CNT_W-1:0] DLY_LAST = CNT_W'(DELAY);
   localparam logic [CNT_W-1:0] LEN_LAST = CNT_W'(LEN - 1);
   localparam phase_e AFTER_WAIT = IMPULSE ? PH_ACT : PH_DONE;

   phase_e           phase_q, phase_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;

   always_comb begin
      phase_d = phase_q;
      cnt_d   = cnt_q;
      if (restart_i) begin
         phase_d = PH_WAIT;
         cnt_d   = '0;
      end else if (adv_i) begin
         unique case (phase_q)
            PH_WAIT: begin
               if (cnt_q == DLY_LAST) begin
                  phase_d = AFTER_WAIT;
                  cnt_d   = '0;
               end else begin
                  cnt_d = cnt_q + 1'b1;
               end
            end
            PH_ACT: begin
               if (cnt_q == LEN_LAST) begin
                  phase_d = PH_DONE;
                  cnt_d   = '0;
               end else begin
                  cnt_d = cnt_q + 1'b1;
               end
            end
            default: begin
               phase_d = PH_DONE;
               cnt_d   = '0;
            end
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         phase_q <= PH_WAIT;
         cnt_q   <= '0;
      end else begin
         phase_q <= phase_d;
         cnt_q   <= cnt_d;
      end
   end

   assign phase_o = phase_q;

endmodule

// File: rtl/pulse_gen_shaper.sv
module pulse_gen_shaper
   import pulse_gen_pkg::*;
#(
   parameter pshape_e SHAPE = PSHAPE_RISE
) (
   input  phase_e phase_i,
   output logic   wave_o
);

   generate
      if (SHAPE == PSHAPE_FALL) begin : g_fall
         assign wave_o = (phase_i == PH_WAIT);
      end else if (SHAPE == PSHAPE_IMPULSE) begin : g_imp
         assign wave_o = (phase_i == PH_ACT);
      end else begin : g_rise
         assign wave_o = (phase_i != PH_WAIT);
      end
   endgenerate

endmodule

// File: rtl/oneshot_wavegen.sv
module oneshot_wavegen
   import pulse_gen_pkg::*;
#(
   parameter pshape_e     SHAPE    = PSHAPE_RISE,
   parameter int unsigned DELAY    = 4,
   parameter int unsigned LEN      = 1,
   parameter bit          USE_ENA  = 1'b1,
   parameter bit          USE_SCLR = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic ena_i,
   input  logic sclr_i,
   output logic wave_o
);

   localparam bit IS_IMPULSE = (SHAPE == PSHAPE_IMPULSE);

   generate
      if (LEN < 1) begin : g_bad_len
         $error("oneshot_wavegen: LEN must be at least 1");
      end
      if (SHAPE != PSHAPE_RISE && SHAPE != PSHAPE_FALL && SHAPE != PSHAPE_IMPULSE) begin : g_bad_shape
         $error("oneshot_wavegen: SHAPE code not supported");
      end
   endgenerate

   logic   adv, restart;
   phase_e phase;

   pulse_gen_gate #(
      .USE_ENA  (USE_ENA),
      .USE_SCLR (USE_SCLR)
   ) u_gate (
      .ena_i     (ena_i),
      .sclr_i    (sclr_i),
      .adv_o     (adv),
      .restart_o (restart)
   );

   pulse_gen_seq #(
      .DELAY   (DELAY),
      .LEN     (LEN),
      .IMPULSE (IS_IMPULSE)
   ) u_seq (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .adv_i     (adv),
      .restart_i (restart),
      .phase_o   (phase)
   );

   pulse_gen_shaper #(
      .SHAPE (SHAPE)
   ) u_shape (
      .phase_i (phase),
      .wave_o  (wave_o)
   );

endmodule

// File: rtl/oneshot_wavegen_chk.sv
module oneshot_wavegen_chk
   import pulse_gen_pkg::*;
#(
   parameter pshape_e     SHAPE    = PSHAPE_RISE,
   parameter int unsigned LEN      = 1,
   parameter bit          USE_ENA  = 1'b1,
   parameter bit          USE_SCLR = 1'b1
) (
   input logic clk_i,
   input logic rst_ni,
   input logic ena_i,
   input logic sclr_i,
   input logic wave_o
);

   localparam logic INIT_LVL = (SHAPE == PSHAPE_FALL);

   logic clr_eff, ena_eff;
   assign clr_eff = USE_SCLR & sclr_i;
   assign ena_eff = USE_ENA ? ena_i : 1'b1;

   // Advancing edges seen while the output is high.
   int unsigned run_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 run_q <= 0;
      else if (clr_eff || !wave_o) run_q <= 0;
      else if (ena_eff)            run_q <= run_q + 1;
   end

   AST_RISE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (SHAPE == PSHAPE_RISE && wave_o && !clr_eff) |=> wave_o); // R1

   AST_FALL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (SHAPE == PSHAPE_FALL && !wave_o && !clr_eff) |=> !wave_o); // R2

   AST_PULSE_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (SHAPE == PSHAPE_IMPULSE && wave_o) |-> (run_q < LEN)); // R3

   AST_STALL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ena_eff && !clr_eff) |=> $stable(wave_o)); // R5

   AST_CLEAR_INIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_eff |=> (wave_o == INIT_LVL)); // R6

endmodule

bind oneshot_wavegen oneshot_wavegen_chk #(
   .SHAPE    (SHAPE),
   .LEN      (LEN),
   .USE_ENA  (USE_ENA),
   .USE_SCLR (USE_SCLR)
) u_chk (
   .clk_i  (clk_i),
   .rst_ni (rst_ni),
   .ena_i  (ena_i),
   .sclr_i (sclr_i),
   .wave_o (wave_o)
);

// File: tb/oneshot_wavegen_tb_top.sv
module oneshot_wavegen_tb_top;
   import pulse_gen_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int KSAT       = 100000;

   // Four configurations: rise D=3, fall D=0, impulse D=2 L=3, impulse D=1 L=1 with options off.
   localparam int D_UP = 3, D_DN = 0, D_IM = 2, L_IM = 3, D_OF = 1, L_OF = 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ena = 1'b0;
   logic sclr = 1'b0;
   logic w_up, w_dn, w_im, w_of;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;
   string phase_tag = "R9";

   always #(CLK_PERIOD/2) clk = ~clk;

   oneshot_wavegen #(.SHAPE(PSHAPE_RISE), .DELAY(D_UP), .LEN(1)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .ena_i(ena), .sclr_i(sclr), .wave_o(w_up));
   oneshot_wavegen #(.SHAPE(PSHAPE_FALL), .DELAY(D_DN), .LEN(1)) dut_dn (
      .clk_i(clk), .rst_ni(rst_n), .ena_i(ena), .sclr_i(sclr), .wave_o(w_dn));
   oneshot_wavegen #(.SHAPE(PSHAPE_IMPULSE), .DELAY(D_IM), .LEN(L_IM)) dut_im (
      .clk_i(clk), .rst_ni(rst_n), .ena_i(ena), .sclr_i(sclr), .wave_o(w_im));
   oneshot_wavegen #(.SHAPE(PSHAPE_IMPULSE), .DELAY(D_OF), .LEN(L_OF),
                     .USE_ENA(1'b0), .USE_SCLR(1'b0)) dut_of (
      .clk_i(clk), .rst_ni(rst_n), .ena_i(ena), .sclr_i(sclr), .wave_o(w_of));

   // Edge-count model: clear first, then enable (R6, R7); options-off counts every edge (R8).
   int k_opt = 0, k_off = 0;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         k_opt <= 0;
         k_off <= 0;
      end else begin
         if (sclr)     k_opt <= 0;
         else if (ena) k_opt <= (k_opt < KSAT) ? k_opt + 1 : k_opt;
         k_off <= (k_off < KSAT) ? k_off + 1 : k_off;
      end
   end

   function automatic logic expect_lvl(input int shape, input int d, input int l, input int k);
      case (shape)
         0:       return (k > d);
         1:       return !(k > d);
         default: return (k > d) && (k <= d + l);
      endcase
   endfunction

   task automatic check_one(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s (%s) t=%0t actual=%b expected=%b", tag, phase_tag, $time, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         check_one("R1", w_up, expect_lvl(0, D_UP, 1, k_opt));
         check_one("R2", w_dn, expect_lvl(1, D_DN, 1, k_opt));
         check_one("R3", w_im, expect_lvl(2, D_IM, L_IM, k_opt));
         check_one("R8", w_of, expect_lvl(2, D_OF, L_OF, k_off));
      end
   end

   task automatic drive(input logic e, input logic c, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         ena  = e;
         sclr = c;
      end
   endtask

   initial begin
      logic [15:0] lfsr;
      lfsr = 16'hACE1;
      // R9: initial level held under reset
      phase_tag = "R9";
      drive(1'b1, 1'b0, 4);
      @(negedge clk);
      rst_n = 1'b1;
      // R4: free run, includes the delay-0 transition on the first edge
      phase_tag = "R4";
      drive(1'b1, 1'b0, 15);
      // R6: clear taken while enable is low, then stall at the initial level
      phase_tag = "R6";
      drive(1'b0, 1'b1, 1);
      drive(1'b0, 1'b0, 3);
      drive(1'b1, 1'b0, 6);
      // R7: clear on exactly the transition edge of the rise instance
      phase_tag = "R7";
      drive(1'b0, 1'b1, 1);
      drive(1'b1, 1'b0, D_UP);
      drive(1'b1, 1'b1, 1);
      drive(1'b1, 1'b0, 8);
      // R5: pseudo-random enable with occasional clears
      phase_tag = "R5";
      for (int i = 0; i < 600; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         drive(lfsr[1:0] != 2'b00, lfsr[7:3] == 5'd0, 1);
      end
      drive(1'b1, 1'b0, 4);
      @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule